// File: doc/BRIEF.md
# Register-Controlled I2C Master Engine

This block runs single-byte transfers on an I2C bus as a master. Software sets up the transfer in a few byte-wide registers. It loads a target selector that holds a 4-bit device-type nibble and a 3-bit chip-select field, a word address, and a byte to send. A write to the status register then starts either a one-byte write or a one-byte random read.

For a write, the engine sends START, the device address with the write bit, the word address, the data byte and STOP. For a read, it sends START, the device address with the write bit and the word address. It then sends a repeated START and the device address with the read bit, receives one byte, answers it with a NACK and sends STOP. The received byte lands in a read-only register.

Completion and a refused acknowledge are reported in sticky flags that software clears by writing 1. The flags drive a maskable interrupt line. SCL and SDA are open-drain: the block only ever pulls a line low or releases it. Bit timing comes from a quarter-period tick set by `QTR_CYCLES`. The default of 150 gives a 3 us SCL period at 200 MHz. The register port is a plain synchronous write strobe with a combinational read mux; it has no streaming handshake.

Top module: `i2cm_master`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and both bus lines are released. The register offsets are: 0 interrupt enable, 1 status, 2 target selector, 3 word address, 4 transmit byte, 5 received byte.
- R2: Writing status with bit 1 = 1 while idle runs a write transfer. The transmit byte is stored at the word address of the addressed device. Status bit 1 reads 1 while the transfer runs and clears itself at the end, and status bit 0 (write done) is then set.
- R3: Writing status with bit 3 = 1 while idle runs a random read through a repeated START. The byte at the word address appears at offset 5. Status bit 3 clears itself, and status bit 2 (read done) is set.
- R4: The 7-bit device address is {selector[3:0], selector[6:4]}: the type nibble forms address bits 6..3 and the chip-select field forms bits 2..0. A device whose address differs does not respond, and its memory is left untouched.
- R5: A NAK on any address or data byte ends the transfer with STOP. It sets status bit 7, sets the matching done bit and clears the start bit. A read that was refused leaves offset 5 unchanged.
- R6: In status, writing 1 to bit 7, 2 or 0 clears that flag, and writing 0 leaves it unchanged.
- R7: `irq` = enable bit 7 AND ((enable bit 1 AND read done) OR (enable bit 0 AND write done)).
- R8: A start request written while a transfer runs is ignored. If bits 3 and 1 are written together while idle, only the read runs.
- R9: SCL stays high and stays low for at least 2*QTR_CYCLES clock cycles each time. When no transfer runs, both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | SDA line level |
| sda_drive_low | output | 1 | 1 pulls SDA low |

## Verification
The bench puts a behavioural memory device on the wired-AND bus and goes after refusals at each stage. A wrong chip-select causes a NAK on the address. A device that refuses the data byte causes a NAK on the data. A design that skipped STOP, or left the start bit set, would hang on the next poll. A read that was refused must keep the previous received byte, so a design that loaded the register unconditionally would show a changed value. Start requests written while busy and simultaneous read/write requests are also driven. A design without the busy guard would restart mid-transfer and set the wrong done flag. The bench also measures every SCL high and low phase, which catches a divider off by one quarter.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {BC_START, BC_BYTE, BC_STOP} bit_cmd_e;
  typedef enum logic [3:0] {
    SQ_IDLE, SQ_START, SQ_DEVW, SQ_WADR, SQ_DATA,
    SQ_RST, SQ_DEVR, SQ_RDAT, SQ_STOP
  } seq_st_e;
  localparam logic [2:0] OFS_IE     = 3'd0;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_TARGET = 3'd2;
  localparam logic [2:0] OFS_WORD   = 3'd3;
  localparam logic [2:0] OFS_TXD    = 3'd4;
  localparam logic [2:0] OFS_RXD    = 3'd5;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int QTR_CYCLES = 150
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (QTR_CYCLES > 2) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  bit_cmd_e   cmd,
  input  logic [8:0] tx_bits,
  input  logic       sda_in,
  output logic       busy,
  output logic       done,
  output logic [8:0] rx_bits,
  output logic       scl_low,
  output logic       sda_low
);
  logic [1:0] sda_sync;
  logic       active;
  bit_cmd_e   cmd_q;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [8:0] sh;

  assign busy = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sync <= 2'b11;
      active   <= 1'b0;
      cmd_q    <= BC_START;
      q        <= '0;
      bitn     <= '0;
      sh       <= '1;
      rx_bits  <= '0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
      done     <= 1'b0;
    end else begin
      sda_sync <= {sda_sync[0], sda_in};
      done     <= 1'b0;
      if (!active) begin
        if (cmd_valid) begin
          active <= 1'b1;
          cmd_q  <= cmd;
          q      <= '0;
          bitn   <= '0;
          sh     <= tx_bits;
        end
      end else if (tick) begin
        unique case (cmd_q)
          BC_START: begin
            unique case (q)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: scl_low <= 1'b1;
            endcase
          end
          BC_BYTE: begin
            unique case (q)
              2'd0: sda_low <= ~sh[8];
              2'd1: scl_low <= 1'b0;
              2'd2: rx_bits <= {rx_bits[7:0], sda_sync[1]};
              default: begin
                scl_low <= 1'b1;
                sh      <= {sh[7:0], 1'b1};
              end
            endcase
          end
          default: begin
            unique case (q)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              default: ;
            endcase
          end
        endcase
        q <= q + 1'b1;
        if (q == 2'd3) begin
          if (cmd_q != BC_BYTE || bitn == 4'd8) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_sequencer.sv
module i2cm_sequencer
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_rd,
  input  logic       launch_wr,
  input  logic [6:0] dev_addr,
  input  logic [7:0] word_addr,
  input  logic [7:0] tx_byte,
  input  logic       eng_busy,
  input  logic       eng_done,
  input  logic [8:0] eng_rx,
  output logic       cmd_valid,
  output bit_cmd_e   cmd,
  output logic [8:0] tx_bits,
  output logic       finish,
  output logic       fin_rd,
  output logic       fin_nak,
  output logic [7:0] rd_byte
);
  seq_st_e    st;
  logic       issued;
  logic [6:0] dev_q;
  logic [7:0] word_q, data_q;
  logic       nak_ack;

  assign nak_ack   = eng_rx[0];
  assign cmd_valid = (st != SQ_IDLE) && !issued && !eng_busy;
  assign finish    = (st == SQ_STOP) && eng_done;

  always_comb begin
    cmd     = BC_BYTE;
    tx_bits = 9'h1FF;
    unique case (st)
      SQ_START, SQ_RST: cmd = BC_START;
      SQ_STOP:          cmd = BC_STOP;
      SQ_DEVW:          tx_bits = {dev_q, 1'b0, 1'b1};
      SQ_WADR:          tx_bits = {word_q, 1'b1};
      SQ_DATA:          tx_bits = {data_q, 1'b1};
      SQ_DEVR:          tx_bits = {dev_q, 1'b1, 1'b1};
      default:          ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      issued  <= 1'b0;
      dev_q   <= '0;
      word_q  <= '0;
      data_q  <= '0;
      fin_rd  <= 1'b0;
      fin_nak <= 1'b0;
      rd_byte <= '0;
    end else begin
      if (cmd_valid) issued <= 1'b1;
      if (st == SQ_IDLE) begin
        if (launch_rd || launch_wr) begin
          st      <= SQ_START;
          dev_q   <= dev_addr;
          word_q  <= word_addr;
          data_q  <= tx_byte;
          fin_rd  <= launch_rd;
          fin_nak <= 1'b0;
        end
      end else if (eng_done) begin
        issued <= 1'b0;
        unique case (st)
          SQ_START: st <= SQ_DEVW;
          SQ_DEVW:  st <= nak_ack ? SQ_STOP : SQ_WADR;
          SQ_WADR:  st <= nak_ack ? SQ_STOP : (fin_rd ? SQ_RST : SQ_DATA);
          SQ_DATA:  st <= SQ_STOP;
          SQ_RST:   st <= SQ_DEVR;
          SQ_DEVR:  st <= nak_ack ? SQ_STOP : SQ_RDAT;
          SQ_RDAT: begin
            rd_byte <= eng_rx[8:1];
            st      <= SQ_STOP;
          end
          default:  st <= SQ_IDLE;
        endcase
        if ((st == SQ_DEVW || st == SQ_WADR || st == SQ_DATA || st == SQ_DEVR) && nak_ack)
          fin_nak <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master
  import i2cm_pkg::*;
#(
  parameter int QTR_CYCLES = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_drive_low,
  input  logic       sda_in,
  output logic       sda_drive_low
);
  logic       ie_glb, ie_rd, ie_wr;
  logic       nak_f, rd_go, rd_done, wr_go, wr_done;
  logic [3:0] dev_type;
  logic [2:0] dev_cs;
  logic [7:0] word_r, txd_r, rxd_r;
  logic       idle, st_wr, launch_rd, launch_wr;
  logic       tick, eng_busy, eng_done, cmd_valid;
  bit_cmd_e   cmd;
  logic [8:0] tx_bits, eng_rx;
  logic       finish, fin_rd, fin_nak;
  logic [7:0] rd_byte;

  assign idle      = !rd_go && !wr_go;
  assign st_wr     = reg_we && (reg_addr == OFS_STATUS);
  assign launch_rd = st_wr && idle && reg_wdata[3];
  assign launch_wr = st_wr && idle && !reg_wdata[3] && reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ie_glb, ie_rd, ie_wr} <= '0;
      {nak_f, rd_go, rd_done, wr_go, wr_done} <= '0;
      dev_type <= '0;
      dev_cs   <= '0;
      word_r   <= '0;
      txd_r    <= '0;
      rxd_r    <= '0;
    end else begin
      if (reg_we) begin
        unique case (reg_addr)
          OFS_IE:     {ie_glb, ie_rd, ie_wr} <= {reg_wdata[7], reg_wdata[1], reg_wdata[0]};
          OFS_TARGET: {dev_cs, dev_type} <= reg_wdata[6:0];
          OFS_WORD:   word_r <= reg_wdata;
          OFS_TXD:    txd_r  <= reg_wdata;
          OFS_STATUS: begin
            if (reg_wdata[7]) nak_f   <= 1'b0;
            if (reg_wdata[2]) rd_done <= 1'b0;
            if (reg_wdata[0]) wr_done <= 1'b0;
          end
          default: ;
        endcase
      end
      if (launch_rd) rd_go <= 1'b1;
      if (launch_wr) wr_go <= 1'b1;
      if (finish) begin
        rd_go <= 1'b0;
        wr_go <= 1'b0;
        if (fin_rd) rd_done <= 1'b1;
        else        wr_done <= 1'b1;
        if (fin_nak) nak_f <= 1'b1;
        else if (fin_rd) rxd_r <= rd_byte;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_IE:     reg_rdata = {ie_glb, 5'b0, ie_rd, ie_wr};
      OFS_STATUS: reg_rdata = {nak_f, 3'b0, rd_go, rd_done, wr_go, wr_done};
      OFS_TARGET: reg_rdata = {1'b0, dev_cs, dev_type};
      OFS_WORD:   reg_rdata = word_r;
      OFS_TXD:    reg_rdata = txd_r;
      OFS_RXD:    reg_rdata = rxd_r;
      default:    reg_rdata = 8'h00;
    endcase
  end

  assign irq = ie_glb && ((ie_rd && rd_done) || (ie_wr && wr_done));

  i2cm_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  i2cm_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch_rd(launch_rd), .launch_wr(launch_wr),
    .dev_addr({dev_type, dev_cs}), .word_addr(word_r), .tx_byte(txd_r),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_rx(eng_rx),
    .cmd_valid(cmd_valid), .cmd(cmd), .tx_bits(tx_bits),
    .finish(finish), .fin_rd(fin_rd), .fin_nak(fin_nak), .rd_byte(rd_byte)
  );

  i2cm_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd(cmd), .tx_bits(tx_bits), .sda_in(sda_in),
    .busy(eng_busy), .done(eng_done), .rx_bits(eng_rx),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );
endmodule

// File: rtl/i2cm_master_chk.sv
module i2cm_master_chk #(
  parameter int QTR_CYCLES = 150
) (
  input logic clk,
  input logic rst_n,
  input logic scl_low,
  input logic sda_low,
  input logic rd_go,
  input logic wr_go,
  input logic rd_done,
  input logic wr_done,
  input logic ie_glb,
  input logic irq
);
  localparam int RW = $clog2(4 * QTR_CYCLES + 2) + 1;
  localparam logic [RW-1:0] RMAX = '1;
  localparam logic [RW-1:0] MIN_RUN = RW'(2 * QTR_CYCLES);
  logic [RW-1:0] run;
  logic          scl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      scl_prev <= 1'b0;
    end else begin
      scl_prev <= scl_low;
      if (scl_low != scl_prev) run <= 1;
      else if (run != RMAX)    run <= run + 1'b1;
    end
  end

  // R9
  scl_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low != scl_prev) |-> (run >= MIN_RUN));

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_go && !wr_go) |-> (!scl_low && !sda_low));

  // R8
  single_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_go && wr_go));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_glb |-> !irq);

  // R2
  wr_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_go) |-> wr_done);

  // R3
  rd_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_go) |-> rd_done);
endmodule

bind i2cm_master i2cm_master_chk #(.QTR_CYCLES(QTR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .scl_low(scl_drive_low), .sda_low(sda_drive_low),
  .rd_go(rd_go), .wr_go(wr_go), .rd_done(rd_done), .wr_done(wr_done),
  .ie_glb(ie_glb), .irq(irq)
);

// File: tb/tb_i2cm_master.sv
`timescale 1ns/1ps
module tb_i2cm_master;
  localparam int QTR = 4;
  localparam logic [6:0] SLV = 7'h52;   // type 4'hA, chip-select 3'b010

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, scl_dl, sda_dl;
  logic drv = 1'b0;
  wire  scl_w = ~scl_dl;
  wire  sda_w = ~(sda_dl | drv);

  always #2.5 clk = ~clk;

  i2cm_master #(.QTR_CYCLES(QTR)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_drive_low(scl_dl), .sda_in(sda_w), .sda_drive_low(sda_dl)
  );

  // behavioural memory device
  logic [7:0] mem [256];
  logic [7:0] sh, ptr;
  int   sst, bc;
  bit   ack, mack, nak_data, ps, psda;
  localparam int S_IDLE = 0, S_ADDR = 1, S_WA = 2, S_WD = 3, S_RD = 4;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
    sst = S_IDLE; bc = 0; ack = 0; mack = 0; nak_data = 0; ps = 1; psda = 1;
    sh = '0; ptr = '0;
  end

  always @(scl_w or sda_w) begin
    if (scl_w && ps && !sda_w && psda) begin
      sst = S_ADDR; bc = 0; ack = 0; mack = 0; drv = 0;
    end else if (scl_w && ps && sda_w && !psda) begin
      sst = S_IDLE; drv = 0;
    end else if (scl_w && !ps) begin
      if (sst != S_IDLE && !ack) begin
        if (sst != S_RD) sh = {sh[6:0], sda_w};
        bc++;
      end
    end else if (!scl_w && ps) begin
      if (sst == S_IDLE) drv = 0;
      else if (ack) begin
        ack = 0; drv = 0; bc = 0;
        if (sst == S_RD) drv = ~mem[ptr][7];
      end else if (mack) begin
        mack = 0; drv = 0; sst = S_IDLE;
      end else if (bc == 8) begin
        case (sst)
          S_ADDR: if (sh[7:1] == SLV) begin ack = 1; drv = 1; sst = sh[0] ? S_RD : S_WA; end
                  else sst = S_IDLE;
          S_WA:   begin ptr = sh; ack = 1; drv = 1; sst = S_WD; end
          S_WD:   begin mem[ptr] = sh;
                    if (nak_data) begin sst = S_IDLE; drv = 0; end
                    else begin ack = 1; drv = 1; end
                  end
          default: begin drv = 0; mack = 1; end
        endcase
      end else if (sst == S_RD) drv = ~mem[ptr][7 - bc];
    end
    ps = scl_w; psda = sda_w;
  end

  // SCL phase length monitor
  int run_c = 0, min_hi = 1 << 20, min_lo = 1 << 20;
  logic scl_pv = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_dl != scl_pv) begin
      if (scl_pv == 1'b0) min_hi = (run_c < min_hi) ? run_c : min_hi;
      else                min_lo = (run_c < min_lo) ? run_c : min_lo;
      run_c = 1;
    end else run_c++;
    scl_pv = scl_dl;
  end

  int n_run = 0, n_fail = 0;
  bit wd_hit = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin rd(3'd1, s); n++; end while ((s & 8'h0A) != 0 && n < 5000);
    if (n >= 5000) begin wd_hit = 1; chk(0, "watchdog", n, 0); end
  endtask

  // {op(1=read), cs[2:0], word[7:0], byte[7:0], nak}
  localparam logic [20:0] VEC [7] = '{
    {1'b0, 3'd2, 8'h10, 8'h5A, 1'b0},
    {1'b0, 3'd2, 8'h11, 8'hC3, 1'b0},
    {1'b1, 3'd2, 8'h10, 8'h5A, 1'b0},
    {1'b1, 3'd2, 8'h11, 8'hC3, 1'b0},
    {1'b0, 3'd5, 8'h20, 8'h99, 1'b1},
    {1'b1, 3'd0, 8'h10, 8'h00, 1'b1},
    {1'b1, 3'd2, 8'h77, 8'h4B, 1'b0}
  };

  initial begin : main
    logic [7:0] v;
    logic [7:0] last_rx;
    last_rx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1 reg reset", v, 0);
    end
    chk(irq == 0 && scl_dl == 0 && sda_dl == 0, "R1 irq/lines", {irq, scl_dl, sda_dl}, 0);

    for (int i = 0; i < 7; i++) begin
      logic op, nk;
      logic [2:0] cs;
      logic [7:0] wa, by;
      {op, cs, wa, by, nk} = VEC[i];
      wr(3'd2, {1'b0, cs, 4'hA});
      wr(3'd3, wa);
      wr(3'd4, by);
      wr(3'd1, 8'h85);
      wr(3'd1, op ? 8'h08 : 8'h02);
      wait_idle();
      rd(3'd1, v);
      if (op) begin
        chk(v == {nk, 3'b0, 4'b0100}, nk ? "R5 read nak status" : "R3 read status", v, {nk, 3'b0, 4'b0100});
        rd(3'd5, v);
        if (nk) chk(v == last_rx, "R5 rx kept", v, last_rx);
        else begin chk(v == by, "R3 rx byte", v, by); last_rx = by; end
      end else begin
        chk(v == {nk, 3'b0, 4'b0001}, nk ? "R4 write nak status" : "R2 write status", v, {nk, 3'b0, 4'b0001});
        if (nk) chk(mem[wa] == (wa ^ 8'h3C), "R4 other device untouched", mem[wa], wa ^ 8'h3C);
        else    chk(mem[wa] == by, "R2 stored", mem[wa], by);
      end
    end

    // R7 interrupt gating: read done currently set from last vector
    wr(3'd1, 8'h85);
    wr(3'd2, {1'b0, 3'd2, 4'hA}); wr(3'd3, 8'h40); wr(3'd4, 8'hE7);
    wr(3'd1, 8'h02); wait_idle();
    wr(3'd0, 8'h81); @(negedge clk);
    chk(irq == 1, "R7 irq wr enabled", irq, 1);
    wr(3'd0, 8'h01); @(negedge clk);
    chk(irq == 0, "R7 global off", irq, 0);
    wr(3'd0, 8'h82); @(negedge clk);
    chk(irq == 0, "R7 rd enable only", irq, 0);

    // R6 write-1-to-clear
    wr(3'd1, 8'h00); rd(3'd1, v);
    chk(v == 8'h01, "R6 zero write keeps", v, 8'h01);
    wr(3'd0, 8'h81);
    wr(3'd1, 8'h01); rd(3'd1, v);
    chk(v == 8'h00 && irq == 0, "R6 clear wr done", v, 0);

    // R5 data refused by device
    nak_data = 1;
    wr(3'd3, 8'h30); wr(3'd4, 8'h11);
    wr(3'd1, 8'h02); wait_idle();
    rd(3'd1, v);
    chk(v == 8'h81, "R5 data nak", v, 8'h81);
    nak_data = 0;
    wr(3'd1, 8'h80); rd(3'd1, v);
    chk(v == 8'h01, "R6 clear nak only", v, 8'h01);
    wr(3'd1, 8'h85);

    // R8 start while busy is ignored
    wr(3'd3, 8'h50); wr(3'd4, 8'h3A);
    wr(3'd1, 8'h02);
    wr(3'd1, 8'h08);
    rd(3'd1, v);
    chk(v[3] == 0 && v[1] == 1, "R8 busy ignore", v, 8'h02);
    wait_idle(); rd(3'd1, v);
    chk(v == 8'h01, "R8 only write done", v, 8'h01);
    chk(mem[8'h50] == 8'h3A, "R2 busy write stored", mem[8'h50], 8'h3A);

    // R8 both bits: read wins
    wr(3'd1, 8'h85);
    wr(3'd3, 8'h10);
    wr(3'd1, 8'h0A); wait_idle();
    rd(3'd1, v);
    chk(v == 8'h04, "R8 read wins", v, 8'h04);
    rd(3'd5, v);
    chk(v == 8'h5A, "R8 read data", v, 8'h5A);

    // R9 timing and idle release
    chk(min_hi >= 2 * QTR, "R9 scl high", min_hi, 2 * QTR);
    chk(min_lo >= 2 * QTR, "R9 scl low", min_lo, 2 * QTR);
    chk(scl_dl == 0 && sda_dl == 0, "R9 idle release", {scl_dl, sda_dl}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule